// File: doc/BRIEF.md
# DRAM Refresh Cycle Sequencer

This block produces refresh cycles for an asynchronous 1M x 16 DRAM that has one row strobe and two column strobes, one for each byte lane. A single-cycle request starts one refresh, and a mode input selects how it is done.

In row-only refresh the block drives a row address from its own 10-bit counter while the row strobe is low, and both column strobes stay high. In column-before-row refresh both column strobes fall before the row strobe, so the memory's internal counter supplies the row. The address bus then carries zero.

Every minimum interval is given in nanoseconds, per speed grade. Each one is turned into clock cycles by rounding up against a clock-period parameter. A `done` pulse marks the end of the closing precharge. All strobes are active low and come straight from flip-flops.

Top module: `dram_refresh_seq`

## Requirements
- R1: While `rst_ni` is low, `ras_n_o`, `casl_n_o`, `cash_n_o` and `we_n_o` are 1, `addr_o` is 0 and `done_o` is 0.
- R2: Row-only mode (`cbr_mode_i` = 0). A refresh has a setup phase of SU = max(ceil(0/T), ceil(5/T), ceil(10/T), 1) cycles with `ras_n_o` high, then a row-strobe-low phase. Throughout both phases `addr_o` carries the current row. Both column strobes stay 1 for the whole refresh.
- R3: Column-before-row mode (`cbr_mode_i` = 1). Both column strobes go low together for a setup phase of SU = max(ceil(tCSR/T), ceil(10/T), 1) cycles before `ras_n_o` falls. They stay low for the first ceil(tCHR/T) cycles of the row-strobe-low phase and then return to 1. `addr_o` is 0 throughout.
- R4: `we_n_o` is 1 at all times, so the write strobe is high before and after every row-strobe falling edge in both modes.
- R5: `ras_n_o` stays low for ACT = max(ceil(tRAS/T), ceil(10/T), ceil(10/T), ceil(tCHR/T)) cycles. ACT·T never exceeds 10000 ns.
- R6: After the row strobe rises, a precharge phase of max(ceil(tRP/T), ceil(5/T), ceil(10/T), ceil(tRC/T) − ACT) cycles follows, with all strobes high.
- R7: Timing of a refresh and of `done_o`.
  - A request sampled high in idle at clock edge E starts the setup phase on the outputs from E on.
  - `done_o` is 1 for exactly the one cycle after the precharge phase.
  - A new request may be accepted in that cycle.
- R8: Requests that arrive before `done_o` are ignored. The mode is latched when a request is accepted, so changing `cbr_mode_i` during a refresh has no effect on it.
- R9: The row counter starts at 0. It advances by one, wrapping from 1023 to 0, after each row-only refresh. Column-before-row refreshes leave it unchanged.
- R10: `SPEED_GRADE` 0, 1 and 2 select the following ns values, converted with T = `CLK_PERIOD_NS`:

  | Grade | tRAS | tRC | tRP | tCHR | tCSR |
  |---|---|---|---|---|---|
  | 0 | 60 | 105 | 40 | 10 | 5 |
  | 1 | 70 | 125 | 50 | 12 | 5 |
  | 2 | 80 | 150 | 60 | 15 | 10 |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Refresh request, sampled in idle |
| cbr_mode_i | input | 1 | 0 = row-only refresh, 1 = column-before-row refresh |
| ras_n_o | output | 1 | Row strobe, active low |
| casl_n_o | output | 1 | Lower-byte column strobe, active low |
| cash_n_o | output | 1 | Upper-byte column strobe, active low |
| we_n_o | output | 1 | Write strobe, held high |
| addr_o | output | ADDR_W | Row address in row-only mode, zero otherwise |
| done_o | output | 1 | One-cycle pulse when a refresh ends |

## Verification
All outputs are registered from next-state values, so the first setup cycle appears on the same edge that samples the request.

The bench drives the request half a cycle before an edge and calls the following cycle index 0. From index 0 it samples every output once per cycle at the falling clock edge. At each index it compares against a waveform built arithmetically from SU, ACT, precharge and the column hold:
- `ras_n_o` is low on indices SU to SU+ACT−1.
- `done_o` is high only on index SU+ACT+PRE.

Ignored requests and mode changes are checked over the rest of that same waveform and over three idle cycles after `done_o`. Row wraparound is checked at the 1025th row-only refresh.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_ACT, ST_PRE} ref_state_e;

  localparam int T_ASR_NS     = 0;
  localparam int T_CRP_NS     = 5;
  localparam int T_RPC_NS     = 5;
  localparam int T_CP_NS      = 10;
  localparam int T_WRP_NS     = 10;
  localparam int T_WRH_NS     = 10;
  localparam int T_RAH_NS     = 10;
  localparam int T_RAS_MAX_NS = 10000;

  function automatic int ns2cyc(input int ns, input int clk);
    return (ns + clk - 1) / clk;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int t_ras_ns(input int g);
    if (g == 0) return 60; else if (g == 1) return 70; else return 80;
  endfunction

  function automatic int t_rc_ns(input int g);
    if (g == 0) return 105; else if (g == 1) return 125; else return 150;
  endfunction

  function automatic int t_rp_ns(input int g);
    if (g == 0) return 40; else if (g == 1) return 50; else return 60;
  endfunction

  function automatic int t_chr_ns(input int g);
    if (g == 0) return 10; else if (g == 1) return 12; else return 15;
  endfunction

  function automatic int t_csr_ns(input int g);
    if (g == 2) return 10; else return 5;
  endfunction

  function automatic int setup_cyc(input int g, input int clk, input bit cbr);
    if (cbr)
      return imax(imax(ns2cyc(t_csr_ns(g), clk), ns2cyc(T_WRP_NS, clk)), 1);
    return imax(imax(ns2cyc(T_ASR_NS, clk), ns2cyc(T_CRP_NS, clk)),
                imax(ns2cyc(T_WRP_NS, clk), 1));
  endfunction

  function automatic int chr_cyc(input int g, input int clk);
    return ns2cyc(t_chr_ns(g), clk);
  endfunction

  function automatic int act_cyc(input int g, input int clk);
    return imax(imax(ns2cyc(t_ras_ns(g), clk), ns2cyc(T_RAH_NS, clk)),
                imax(ns2cyc(T_WRH_NS, clk), imax(chr_cyc(g, clk), 1)));
  endfunction

  function automatic int pre_cyc(input int g, input int clk);
    return imax(imax(ns2cyc(t_rp_ns(g), clk), ns2cyc(T_RPC_NS, clk)),
                imax(ns2cyc(T_CP_NS, clk), ns2cyc(t_rc_ns(g), clk) - act_cyc(g, clk)));
  endfunction

endpackage

// File: rtl/ref_row_ctr.sv
module ref_row_ctr #(
  parameter int ROW_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [ROW_W-1:0] row_o
);
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    row_q <= '0;
    else if (adv_i) row_q <= row_q + 1'b1;  // wraps naturally
  end

  assign row_o = row_q;
endmodule

// File: rtl/ref_ctrl.sv
module ref_ctrl
  import dram_ref_pkg::*;
#(
  parameter int SU_RO  = 2,
  parameter int SU_CBR = 2,
  parameter int ACT_C  = 8,
  parameter int PRE_C  = 6,
  parameter int CNT_W  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             cbr_mode_i,
  output ref_state_e       state_d_o,
  output logic [CNT_W-1:0] cnt_d_o,
  output logic             cbr_d_o,
  output logic             row_adv_o,
  output logic             done_o
);
  ref_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cbr_q, cbr_d, fin, done_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cbr_d   = cbr_q;
    fin     = 1'b0;
    case (state_q)
      ST_IDLE: if (req_i) begin
        state_d = ST_SETUP;
        cbr_d   = cbr_mode_i;  // latched once per refresh
        cnt_d   = cbr_mode_i ? CNT_W'(SU_CBR - 1) : CNT_W'(SU_RO - 1);
      end
      ST_SETUP: if (cnt_q == '0) begin
        state_d = ST_ACT;
        cnt_d   = CNT_W'(ACT_C - 1);
      end else cnt_d = cnt_q - 1'b1;
      ST_ACT: if (cnt_q == '0) begin
        state_d = ST_PRE;
        cnt_d   = CNT_W'(PRE_C - 1);
      end else cnt_d = cnt_q - 1'b1;
      ST_PRE: if (cnt_q == '0) begin
        state_d = ST_IDLE;
        fin     = 1'b1;
      end else cnt_d = cnt_q - 1'b1;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      cbr_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      cbr_q   <= cbr_d;
      done_q  <= fin;
    end
  end

  assign state_d_o = state_d;
  assign cnt_d_o   = cnt_d;
  assign cbr_d_o   = cbr_d;
  assign row_adv_o = fin & ~cbr_q;
  assign done_o    = done_q;
endmodule

// File: rtl/ref_strobe_gen.sv
module ref_strobe_gen
  import dram_ref_pkg::*;
#(
  parameter int CNT_W   = 4,
  parameter int ACT_C   = 8,
  parameter int CHR_C   = 2,
  parameter int ADDR_W  = 10,
  parameter int NUM_CAS = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  ref_state_e         state_d_i,
  input  logic [CNT_W-1:0]   cnt_d_i,
  input  logic               cbr_d_i,
  input  logic [ADDR_W-1:0]  row_i,
  output logic               ras_n_o,
  output logic [NUM_CAS-1:0] cas_n_o,
  output logic [ADDR_W-1:0]  addr_o
);
  localparam logic [CNT_W-1:0] CAS_REL = CNT_W'(ACT_C - CHR_C);

  logic ras_low, cas_low, drive_row;
  logic ras_n_q;
  logic [ADDR_W-1:0] addr_q;

  // column strobes stay low through setup and the first CHR_C cycles of ACT
  assign ras_low   = (state_d_i == ST_ACT);
  assign cas_low   = cbr_d_i && ((state_d_i == ST_SETUP) ||
                                 (ras_low && (cnt_d_i >= CAS_REL)));
  assign drive_row = !cbr_d_i && ((state_d_i == ST_SETUP) || ras_low);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ras_n_q <= 1'b1;
      addr_q  <= '0;
    end else begin
      ras_n_q <= !ras_low;
      addr_q  <= drive_row ? row_i : '0;
    end
  end

  for (genvar i = 0; i < NUM_CAS; i++) begin : g_cas
    logic cas_n_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cas_n_q <= 1'b1;
      else         cas_n_q <= !cas_low;
    end
    assign cas_n_o[i] = cas_n_q;
  end

  assign ras_n_o = ras_n_q;
  assign addr_o  = addr_q;
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dram_ref_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 8,
  parameter int SPEED_GRADE   = 0,
  parameter int ADDR_W        = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              cbr_mode_i,
  output logic              ras_n_o,
  output logic              casl_n_o,
  output logic              cash_n_o,
  output logic              we_n_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              done_o
);
  localparam int SU_RO  = setup_cyc(SPEED_GRADE, CLK_PERIOD_NS, 1'b0);
  localparam int SU_CBR = setup_cyc(SPEED_GRADE, CLK_PERIOD_NS, 1'b1);
  localparam int ACT_C  = act_cyc(SPEED_GRADE, CLK_PERIOD_NS);
  localparam int CHR_C  = chr_cyc(SPEED_GRADE, CLK_PERIOD_NS);
  localparam int PRE_C  = pre_cyc(SPEED_GRADE, CLK_PERIOD_NS);
  localparam int MAXLEN = imax(imax(SU_RO, SU_CBR), imax(ACT_C, PRE_C));
  localparam int CNT_W  = $clog2(MAXLEN + 1);

  ref_state_e        state_d;
  logic [CNT_W-1:0]  cnt_d;
  logic              cbr_d, row_adv;
  logic [ADDR_W-1:0] row;
  logic [1:0]        cas_n;

  ref_ctrl #(
    .SU_RO(SU_RO), .SU_CBR(SU_CBR), .ACT_C(ACT_C), .PRE_C(PRE_C), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk_i, .rst_ni, .req_i, .cbr_mode_i,
    .state_d_o(state_d), .cnt_d_o(cnt_d), .cbr_d_o(cbr_d),
    .row_adv_o(row_adv), .done_o(done_o)
  );

  ref_row_ctr #(.ROW_W(ADDR_W)) u_row (
    .clk_i, .rst_ni, .adv_i(row_adv), .row_o(row)
  );

  ref_strobe_gen #(
    .CNT_W(CNT_W), .ACT_C(ACT_C), .CHR_C(CHR_C), .ADDR_W(ADDR_W), .NUM_CAS(2)
  ) u_strb (
    .clk_i, .rst_ni, .state_d_i(state_d), .cnt_d_i(cnt_d), .cbr_d_i(cbr_d),
    .row_i(row), .ras_n_o(ras_n_o), .cas_n_o(cas_n), .addr_o(addr_o)
  );

  assign casl_n_o = cas_n[0];
  assign cash_n_o = cas_n[1];
  assign we_n_o   = 1'b1;  // refresh never writes
endmodule

// File: rtl/ref_seq_chk.sv
module ref_seq_chk
  import dram_ref_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 8,
  parameter int SPEED_GRADE   = 0,
  parameter int ADDR_W        = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ras_n_o,
  input logic              casl_n_o,
  input logic              cash_n_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              done_o
);
  localparam int ACT_C     = act_cyc(SPEED_GRADE, CLK_PERIOD_NS);
  localparam int PRE_C     = pre_cyc(SPEED_GRADE, CLK_PERIOD_NS);
  localparam int RAS_MAX_C = T_RAS_MAX_NS / CLK_PERIOD_NS;

  logic [15:0] low_cnt, hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_cnt <= '0;
      hi_cnt  <= '1;
    end else if (!ras_n_o) begin
      low_cnt <= low_cnt + 1'b1;
      hi_cnt  <= '0;
    end else begin
      low_cnt <= '0;
      if (hi_cnt != '1) hi_cnt <= hi_cnt + 1'b1;
    end
  end

  AST_CAS_LANES_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    casl_n_o == cash_n_o);  // R3
  AST_CBR_CAS_SETUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ras_n_o) && !casl_n_o) |-> !$past(casl_n_o));  // R3
  AST_CBR_ADDR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !casl_n_o |-> (addr_o == '0));  // R3
  AST_ROW_ADDR_SETUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ras_n_o) && casl_n_o) |-> $stable(addr_o));  // R2
  AST_RAS_MIN_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_n_o) |-> (low_cnt >= 16'(ACT_C)));  // R5
  AST_RAS_MAX_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ras_n_o |-> (low_cnt < 16'(RAS_MAX_C)));  // R5
  AST_RAS_MIN_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) |-> (hi_cnt >= 16'(PRE_C)));  // R6
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);  // R7
  AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (ras_n_o && casl_n_o && $past(ras_n_o)));  // R7
endmodule

bind dram_refresh_seq ref_seq_chk #(
  .CLK_PERIOD_NS(CLK_PERIOD_NS), .SPEED_GRADE(SPEED_GRADE), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ras_n_o(ras_n_o), .casl_n_o(casl_n_o),
  .cash_n_o(cash_n_o), .addr_o(addr_o), .done_o(done_o)
);

// File: tb/tb_dram_refresh_seq.sv
`timescale 1ns/1ps
module tb_dram_refresh_seq;
  localparam int CLK_NS = 8;
  localparam int AW     = 10;

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, mode = 1'b0, sel = 1'b0;
  logic ras0, casl0, cash0, we0, done0, ras1, casl1, cash1, we1, done1;
  logic [AW-1:0] addr0, addr1;
  logic req0, req1, ras, casl, cash, we, done;
  logic [AW-1:0] addr;
  int n_chk = 0, n_bad = 0;
  int exp_row = 0;

  always #4 clk = ~clk;

  assign req0 = req & ~sel;
  assign req1 = req & sel;
  assign ras  = sel ? ras1  : ras0;
  assign casl = sel ? casl1 : casl0;
  assign cash = sel ? cash1 : cash0;
  assign we   = sel ? we1   : we0;
  assign done = sel ? done1 : done0;
  assign addr = sel ? addr1 : addr0;

  dram_refresh_seq #(.CLK_PERIOD_NS(CLK_NS), .SPEED_GRADE(0), .ADDR_W(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req0), .cbr_mode_i(mode),
    .ras_n_o(ras0), .casl_n_o(casl0), .cash_n_o(cash0), .we_n_o(we0),
    .addr_o(addr0), .done_o(done0));

  dram_refresh_seq #(.CLK_PERIOD_NS(CLK_NS), .SPEED_GRADE(2), .ADDR_W(AW)) dut_g2 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req1), .cbr_mode_i(mode),
    .ras_n_o(ras1), .casl_n_o(casl1), .cash_n_o(cash1), .we_n_o(we1),
    .addr_o(addr1), .done_o(done1));

  int g_ras[3] = '{60, 70, 80};
  int g_rc[3]  = '{105, 125, 150};
  int g_rp[3]  = '{40, 50, 60};
  int g_chr[3] = '{10, 12, 15};
  int g_csr[3] = '{5, 5, 10};

  function automatic int cyc(input int ns);
    return (ns + CLK_NS - 1) / CLK_NS;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // one refresh on the selected instance; poke = stray request and mode flip mid-cycle (R8)
  task automatic run_ref(input bit cbr, input bit poke);
    int g, su, act, pre, chr, tot, row;
    bit e_ras, e_cas;
    int e_addr;
    g   = sel ? 2 : 0;
    su  = cbr ? mx(mx(cyc(g_csr[g]), cyc(10)), 1) : mx(mx(cyc(0), cyc(5)), mx(cyc(10), 1));
    chr = cyc(g_chr[g]);
    act = mx(mx(cyc(g_ras[g]), cyc(10)), mx(cyc(10), chr));
    pre = mx(mx(cyc(g_rp[g]), cyc(5)), mx(cyc(10), cyc(g_rc[g]) - act));
    tot = su + act + pre;
    row = sel ? 0 : exp_row;
    req = 1'b1; mode = cbr;
    @(negedge clk);
    req = 1'b0;
    for (int k = 0; k <= tot; k++) begin
      if (poke && k == 3) mode = !cbr;
      if (poke && k == 4) req = 1'b1;
      if (poke && k == 5) req = 1'b0;
      e_ras  = !(k >= su && k < su + act);
      e_cas  = !(cbr && k < su + chr);
      e_addr = (!cbr && k < su + act) ? row : 0;
      chk(ras == e_ras, sel ? "R10 ras" : (e_ras ? "R6 ras" : "R5 ras"), ras, e_ras);
      chk(casl == e_cas && cash == e_cas, sel ? "R10 cas" : (cbr ? "R3 cas" : "R2 cas"),
          {casl, cash}, {e_cas, e_cas});
      chk(we == 1'b1, "R4 we", we, 1);
      chk(addr == AW'(e_addr), cbr ? "R3 addr" : "R2 addr", addr, e_addr);
      chk(done == (k == tot), poke ? "R8 done" : "R7 done", done, k == tot);
      @(negedge clk);
    end
    mode = cbr;
    if (poke) begin
      for (int j = 0; j < 3; j++) begin
        chk(ras == 1'b1 && done == 1'b0, "R8 idle after ignored request", {ras, done}, 2);
        @(negedge clk);
      end
    end
    if (!sel && !cbr) exp_row = (exp_row + 1) % (1 << AW);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ras0 && casl0 && cash0 && we0, "R1 strobes in reset", {ras0, casl0, cash0, we0}, 15);
    chk(addr0 == '0 && done0 == 1'b0, "R1 addr/done in reset", {addr0, done0}, 0);
    chk(ras1 && casl1 && cash1, "R1 grade2 strobes in reset", {ras1, casl1, cash1}, 7);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R5 R6 R7: row-only refreshes, back-to-back
    run_ref(1'b0, 1'b0);
    run_ref(1'b0, 1'b0);
    // R3: column-before-row, row counter must not move (R9)
    run_ref(1'b1, 1'b0);
    run_ref(1'b1, 1'b0);
    run_ref(1'b0, 1'b0);
    // R8: busy requests and mode flips ignored
    run_ref(1'b0, 1'b1);
    run_ref(1'b1, 1'b1);
    repeat (4) @(negedge clk);
    // R9: sweep the full row space and past the wrap
    while (exp_row != 0) run_ref(1'b0, 1'b0);
    chk(exp_row == 0, "R9 wrap reached", exp_row, 0);
    run_ref(1'b0, 1'b0);  // addr 0 after wrap, checked inside
    run_ref(1'b0, 1'b0);
    // R10: slowest grade on the second instance
    sel = 1'b1;
    @(negedge clk);
    run_ref(1'b1, 1'b0);
    run_ref(1'b0, 1'b0);
    sel = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule